// File: doc/BRIEF.md
# Instruction-Fetch Overlay Automapper

This block sits beside a Z80-style processor and decides, cycle by cycle, whether the lower 16K of the address space shows the host ROM or a disk-interface overlay. The overlay is an 8K ROM at 0x0000–0x1FFF and one 8K page of banked RAM at 0x2000–0x3FFF. The switch is tied to opcode fetches. At most trap addresses the mapping changes during the refresh half of the fetch cycle. The opcode byte therefore comes from one memory and the operand bytes come from the other.

There are three kinds of trap. Six fixed entry addresses map the overlay in after their opcode byte. An opcode fetch anywhere in the 0x3D00–0x3DFF page maps it in before the byte is read. An opcode fetch in 0x1FF8–0x1FFF maps it out after the byte is read. A small control register, written through an I/O port, holds a force bit that shows the overlay at once and a bank number that selects the RAM page. The bench drives the bus at one phase per clock (fetch, refresh, memory or I/O access). The select lines follow the address within the same phase.

Top module: `ovl_automap`

## Requirements
- R1: An opcode fetch (m1_n and mreq_n both low) at 0x0000, 0x0008, 0x0038, 0x0066, 0x04C6 or 0x0562 while unmapped reads its byte from the host ROM (sel_host_rom high). A fetch at a neighbouring address such as 0x0009 or 0x3CFF sets up no mapping.
- R2: A delayed entry or exit request takes effect at the refresh phase (rfsh_n and mreq_n low) of the same M1 cycle. The next memory access already sees the new mapping.
- R3: An opcode fetch at 0x3D00–0x3DFF selects overlay RAM for that same byte, and the overlay then stays mapped.
- R4: An opcode fetch at 0x1FF8–0x1FFF while mapped reads its byte from the overlay ROM. After the refresh phase, the host ROM is selected. A fetch at 0x1FF7 does not unmap.
- R5: While the force bit is set, every access to 0x0000–0x3FFF selects the overlay, whatever the mapped state. Clearing the bit brings back the selection given by the mapped state.
- R6: An I/O write (iorq_n and wr_n low, m1_n high) with address bits [7:0] equal to 0xE3 loads the control register: data bit 7 is the force bit and data bits [3:0] are the RAM bank. ovl_ram_addr is {bank, cpu_addr[12:0]}, which covers 128K. A write to any other port changes nothing.
- R7: Memory reads, memory writes and I/O cycles at trap addresses never change the mapped state.
- R8: At most one select line is high. No select is high outside 0x0000–0x3FFF, during refresh, or when mreq_n is high. When mapped, 0x0000–0x1FFF selects the overlay ROM and 0x2000–0x3FFF selects the overlay RAM.
- R9: A second fetch at 0x0066 while already mapped reads its opcode from the overlay ROM (a nested NMI), and the overlay stays mapped.
- R10: Reset clears the mapped state, any pending request and the control register, so ovl_active is low and the host ROM is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus phases are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus, used for control-register writes |
| m1_n | input | 1 | Opcode-fetch strobe, active low |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| wr_n | input | 1 | Write strobe, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| sel_host_rom | output | 1 | Host ROM supplies this access |
| sel_ovl_rom | output | 1 | Overlay ROM supplies this access |
| sel_ovl_ram | output | 1 | Overlay RAM supplies this access |
| ovl_ram_addr | output | 17 | Overlay RAM address: bank and page offset |
| ovl_active | output | 1 | Overlay mapped or forced |

## Verification
The assertions assume that each bus phase lasts one clock. They also assume that a refresh phase never overlaps an opcode fetch, and that m1_n is high during an I/O write. Under these conditions, a mapping change can be traced to exactly one fetch or refresh edge. The stimulus tasks build every cycle from named phases: fetch, refresh, memory access, I/O write and idle. They hold each phase for one clock and always return to idle, so no overlapping strobe patterns are produced.

// File: rtl/ovl_automap_pkg.sv
package ovl_automap_pkg;

  localparam int NUM_ENTRY = 6;

  localparam logic [15:0] ENTRY_ADDR [NUM_ENTRY] = '{
    16'h0000, 16'h0008, 16'h0038, 16'h0066, 16'h04C6, 16'h0562
  };

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_MAP   = 2'd1,
    PEND_UNMAP = 2'd2
  } pend_e;

  typedef struct packed {
    logic fetch;
    logic refresh;
    logic mem_acc;
    logic io_wr;
  } bus_ev_t;

endpackage

// File: rtl/ovl_trap_decode.sv
module ovl_trap_decode
  import ovl_automap_pkg::*;
#(
  parameter logic [15:0] IMM_BASE   = 16'h3D00,
  parameter int          IMM_LOG2   = 8,
  parameter logic [15:0] EXIT_BASE  = 16'h1FF8,
  parameter int          EXIT_LOG2  = 3
) (
  input  logic [15:0] addr,
  output logic        entry_hit,
  output logic        imm_hit,
  output logic        exit_hit
);

  logic [NUM_ENTRY-1:0] match_v;

  for (genvar i = 0; i < NUM_ENTRY; i++) begin : g_entry
    assign match_v[i] = (addr == ENTRY_ADDR[i]);
  end

  assign entry_hit = |match_v;
  assign imm_hit   = (addr[15:IMM_LOG2]  == IMM_BASE[15:IMM_LOG2]);
  assign exit_hit  = (addr[15:EXIT_LOG2] == EXIT_BASE[15:EXIT_LOG2]);

endmodule

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg #(
  parameter int         BANK_W    = 4,
  parameter logic [7:0] PORT_ADDR = 8'hE3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [7:0]        port_lo,
  input  logic              force_in,
  input  logic [BANK_W-1:0] bank_in,
  output logic              force_q,
  output logic [BANK_W-1:0] bank_q
);

  logic hit;
  assign hit = io_wr && (port_lo == PORT_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      force_q <= 1'b0;
      bank_q  <= '0;
    end else if (hit) begin
      force_q <= force_in;
      bank_q  <= bank_in;
    end
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(force_q) && $stable(bank_q))); // R6

endmodule

// File: rtl/ovl_map_state.sv
module ovl_map_state
  import ovl_automap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fetch,
  input  logic refresh,
  input  logic entry_hit,
  input  logic imm_hit,
  input  logic exit_hit,
  output logic mapped_q
);

  pend_e pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mapped_q <= 1'b0;
      pend_q   <= PEND_NONE;
    end else if (fetch) begin
      if (imm_hit) begin
        mapped_q <= 1'b1;
        pend_q   <= PEND_NONE;
      end else if (entry_hit) begin
        pend_q   <= PEND_MAP;
      end else if (exit_hit) begin
        pend_q   <= PEND_UNMAP;
      end else begin
        pend_q   <= PEND_NONE;
      end
    end else if (refresh) begin
      case (pend_q)
        PEND_MAP:   mapped_q <= 1'b1;
        PEND_UNMAP: mapped_q <= 1'b0;
        default:    mapped_q <= mapped_q;
      endcase
      pend_q <= PEND_NONE;
    end
  end

  AST_COMMIT_MAP: assert property (@(posedge clk) disable iff (rst)
    (refresh && pend_q == PEND_MAP) |=> mapped_q); // R2
  AST_COMMIT_UNMAP: assert property (@(posedge clk) disable iff (rst)
    (refresh && pend_q == PEND_UNMAP) |=> !mapped_q); // R4
  AST_IMM_MAP: assert property (@(posedge clk) disable iff (rst)
    (fetch && imm_hit) |=> mapped_q); // R3
  AST_NO_DATA_TRAP: assert property (@(posedge clk) disable iff (rst)
    (!fetch && !refresh) |=> $stable(mapped_q)); // R7
  AST_FETCH_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (fetch && !imm_hit) |=> $stable(mapped_q)); // R2

endmodule

// File: rtl/ovl_mem_select.sv
module ovl_mem_select #(
  parameter int BANK_W  = 4,
  parameter int PAGE_AW = 13,
  localparam int RAM_AW = BANK_W + PAGE_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_acc,
  input  logic [15:0]       addr,
  input  logic              mapped_q,
  input  logic              force_map,
  input  logic              imm_now,
  input  logic [BANK_W-1:0] bank,
  output logic              sel_host_rom,
  output logic              sel_ovl_rom,
  output logic              sel_ovl_ram,
  output logic [RAM_AW-1:0] ram_addr
);

  logic low16, eff_map;

  assign low16   = (addr[15:PAGE_AW+1] == '0);
  assign eff_map = mapped_q | force_map | imm_now;

  always_comb begin
    sel_host_rom = mem_acc && low16 && !eff_map;
    sel_ovl_rom  = mem_acc && low16 &&  eff_map && !addr[PAGE_AW];
    sel_ovl_ram  = mem_acc && low16 &&  eff_map &&  addr[PAGE_AW];
    ram_addr     = {bank, addr[PAGE_AW-1:0]};
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_host_rom, sel_ovl_rom, sel_ovl_ram})); // R8
  AST_IMM_BYTE: assert property (@(posedge clk) disable iff (rst)
    (imm_now && mem_acc) |-> sel_ovl_ram); // R3
  AST_FORCE_OVL: assert property (@(posedge clk) disable iff (rst)
    (force_map && mem_acc && low16) |-> !sel_host_rom); // R5
  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (rst)
    !mem_acc |-> !(sel_host_rom || sel_ovl_rom || sel_ovl_ram)); // R8

endmodule

// File: rtl/ovl_automap.sv
module ovl_automap
  import ovl_automap_pkg::*;
#(
  parameter int         BANK_W    = 4,
  parameter int         PAGE_AW   = 13,
  parameter logic [7:0] PORT_ADDR = 8'hE3,
  localparam int        RAM_AW    = BANK_W + PAGE_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              m1_n,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              wr_n,
  input  logic              rfsh_n,
  output logic              sel_host_rom,
  output logic              sel_ovl_rom,
  output logic              sel_ovl_ram,
  output logic [RAM_AW-1:0] ovl_ram_addr,
  output logic              ovl_active
);

  bus_ev_t ev;
  logic entry_hit, imm_hit, exit_hit;
  logic mapped_q, force_q;
  logic [BANK_W-1:0] bank_q;

  always_comb begin
    ev.fetch   = !m1_n && !mreq_n;
    ev.refresh = !rfsh_n && !mreq_n;
    ev.mem_acc = !mreq_n && rfsh_n;
    ev.io_wr   = !iorq_n && !wr_n && m1_n;
  end

  ovl_trap_decode u_dec (
    .addr      (cpu_addr),
    .entry_hit (entry_hit),
    .imm_hit   (imm_hit),
    .exit_hit  (exit_hit)
  );

  ovl_ctrl_reg #(.BANK_W(BANK_W), .PORT_ADDR(PORT_ADDR)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .io_wr    (ev.io_wr),
    .port_lo  (cpu_addr[7:0]),
    .force_in (cpu_data[7]),
    .bank_in  (cpu_data[BANK_W-1:0]),
    .force_q  (force_q),
    .bank_q   (bank_q)
  );

  ovl_map_state u_state (
    .clk       (clk),
    .rst       (rst),
    .fetch     (ev.fetch),
    .refresh   (ev.refresh),
    .entry_hit (entry_hit),
    .imm_hit   (imm_hit),
    .exit_hit  (exit_hit),
    .mapped_q  (mapped_q)
  );

  ovl_mem_select #(.BANK_W(BANK_W), .PAGE_AW(PAGE_AW)) u_sel (
    .clk          (clk),
    .rst          (rst),
    .mem_acc      (ev.mem_acc),
    .addr         (cpu_addr),
    .mapped_q     (mapped_q),
    .force_map    (force_q),
    .imm_now      (ev.fetch && imm_hit),
    .bank         (bank_q),
    .sel_host_rom (sel_host_rom),
    .sel_ovl_rom  (sel_ovl_rom),
    .sel_ovl_ram  (sel_ovl_ram),
    .ram_addr     (ovl_ram_addr)
  );

  assign ovl_active = mapped_q | force_q;

  AST_EXIT_OPCODE: assert property (@(posedge clk) disable iff (rst)
    (ev.fetch && exit_hit && mapped_q) |-> sel_ovl_rom); // R4
  AST_NESTED_NMI: assert property (@(posedge clk) disable iff (rst)
    (ev.fetch && cpu_addr == 16'h0066 && mapped_q) |-> sel_ovl_rom); // R9

endmodule

// File: tb/sim_ovl_automap.sv
module sim_ovl_automap;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        m1_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1, wr_n = 1'b1, rfsh_n = 1'b1;
  logic        sel_host_rom, sel_ovl_rom, sel_ovl_ram, ovl_active;
  logic [16:0] ovl_ram_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [2:0] HOST = 3'b100, OROM = 3'b010, ORAM = 3'b001, NONE = 3'b000;

  always #10 clk = ~clk;

  ovl_automap u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .wr_n(wr_n), .rfsh_n(rfsh_n),
    .sel_host_rom(sel_host_rom), .sel_ovl_rom(sel_ovl_rom), .sel_ovl_ram(sel_ovl_ram),
    .ovl_ram_addr(ovl_ram_addr), .ovl_active(ovl_active)
  );

  task automatic chk_sel(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {sel_host_rom, sel_ovl_rom, sel_ovl_ram};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h sel act=%b exp=%b", req, cpu_addr, act, exp);
    end
  endtask

  task automatic chk_val(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic phase(input logic m1, input logic mreq, input logic rf,
                       input logic iorq, input logic wr, input logic [15:0] a,
                       input logic [7:0] d);
    @(negedge clk);
    m1_n = m1; mreq_n = mreq; rfsh_n = rf; iorq_n = iorq; wr_n = wr;
    cpu_addr = a; cpu_data = d;
    #2;
  endtask

  task automatic idle();  phase(1, 1, 1, 1, 1, 16'hFFFF, 8'h00); endtask
  task automatic ph_fetch(input logic [15:0] a); phase(0, 0, 1, 1, 1, a, 8'h00); endtask
  task automatic ph_rfsh();  phase(1, 0, 0, 1, 1, 16'h0012, 8'h00); endtask
  task automatic ph_read(input logic [15:0] a);  phase(1, 0, 1, 1, 1, a, 8'h00); endtask
  task automatic ph_write(input logic [15:0] a); phase(1, 0, 1, 1, 0, a, 8'h55); endtask
  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    phase(1, 1, 1, 0, 0, a, d);
    idle();
  endtask

  // full M1 cycle: fetch checked against exp, then refresh
  task automatic m1_cycle(input logic [15:0] a, input logic [2:0] exp, input string req);
    ph_fetch(a);
    chk_sel(req, exp);
    ph_rfsh();
    idle();
  endtask

  task automatic rd_check(input logic [15:0] a, input logic [2:0] exp, input string req);
    ph_read(a);
    chk_sel(req, exp);
    idle();
  endtask

  task automatic unmap_all();
    m1_cycle(16'h1FF8, OROM, "R4 exit opcode");
  endtask

  task automatic t_reset();
    idle();
    chk_val("R10 ovl_active", {16'h0, ovl_active}, 17'h0);
    rd_check(16'h0100, HOST, "R10 host after reset");
    chk_val("R10 bank zero", ovl_ram_addr, 17'h0FFFF & 17'h01FFF);
  endtask

  task automatic t_data_no_trap();
    rd_check(16'h0038, HOST, "R7 data read at trap");
    ph_rfsh(); idle();
    rd_check(16'h0039, HOST, "R7 no map after data read");
    ph_write(16'h0000); chk_sel("R7 write at trap", HOST); idle();
    ph_rfsh(); idle();
    phase(1, 1, 1, 0, 1, 16'h0066, 8'h00);
    chk_sel("R8 io cycle no select", NONE);
    idle();
    rd_check(16'h0100, HOST, "R7 still unmapped");
  endtask

  task automatic t_entry_delay();
    m1_cycle(16'h0008, HOST, "R1 entry opcode from host");
    rd_check(16'h0009, OROM, "R2 operand from overlay");
    chk_val("R2 ovl_active", {16'h0, ovl_active}, 17'h1);
    unmap_all();
    rd_check(16'h1FF9, HOST, "R4 operand from host");
  endtask

  task automatic t_each_entry();
    logic [15:0] tr [6] = '{16'h0000, 16'h0008, 16'h0038, 16'h0066, 16'h04C6, 16'h0562};
    for (int i = 0; i < 6; i++) begin
      m1_cycle(tr[i], HOST, "R1 each entry opcode");
      rd_check(tr[i] + 16'h1, OROM, "R1 each entry maps");
      unmap_all();
    end
  endtask

  task automatic t_imm();
    m1_cycle(16'h3D2F, ORAM, "R3 immediate byte from overlay");
    rd_check(16'h0100, OROM, "R3 stays mapped");
    unmap_all();
    m1_cycle(16'h3DFF, ORAM, "R3 top of range");
    unmap_all();
    m1_cycle(16'h3CFF, HOST, "R1 below range no map");
    rd_check(16'h3CFF, HOST, "R3 below range unmapped");
  endtask

  task automatic t_boundaries();
    m1_cycle(16'h0009, HOST, "R1 near-miss fetch");
    rd_check(16'h000A, HOST, "R1 near-miss no map");
    m1_cycle(16'h0038, HOST, "R1 map for exit test");
    m1_cycle(16'h1FF7, OROM, "R4 below exit range");
    rd_check(16'h0100, OROM, "R4 1FF7 does not unmap");
    m1_cycle(16'h1FFF, OROM, "R4 top exit opcode");
    rd_check(16'h0100, HOST, "R4 unmapped after 1FFF");
  endtask

  task automatic t_nested_nmi();
    m1_cycle(16'h0066, HOST, "R9 first NMI opcode from host");
    m1_cycle(16'h0066, OROM, "R9 nested NMI opcode from overlay");
    rd_check(16'h0067, OROM, "R9 still mapped");
    unmap_all();
  endtask

  task automatic t_bank();
    io_write(16'h00E3, 8'h05);
    m1_cycle(16'h0000, HOST, "R1 map for bank test");
    rd_check(16'h2345, ORAM, "R8 upper half overlay RAM");
    ph_read(16'h2345);
    chk_val("R6 bank 5 address", ovl_ram_addr, 17'h0A345);
    idle();
    io_write(16'h12E3, 8'h0F);
    ph_read(16'h3FFF);
    chk_val("R6 bank 15 address", ovl_ram_addr, 17'h1FFFF);
    idle();
    unmap_all();
    io_write(16'h00E3, 8'h00);
  endtask

  task automatic t_force();
    io_write(16'h00E3, 8'h80);
    rd_check(16'h0100, OROM, "R5 force low half");
    rd_check(16'h2000, ORAM, "R5 force upper half");
    m1_cycle(16'h1FFA, OROM, "R5 exit while forced");
    rd_check(16'h1FFB, OROM, "R5 forced after exit");
    io_write(16'h00E3, 8'h00);
    rd_check(16'h0100, HOST, "R5 cleared returns host");
  endtask

  task automatic t_port_mismatch();
    io_write(16'h00E7, 8'h80);
    rd_check(16'h0100, HOST, "R6 other port ignored");
    phase(0, 1, 1, 0, 0, 16'h00E3, 8'h80); // interrupt-ack style, m1 low
    idle();
    rd_check(16'h0100, HOST, "R6 write with m1 low ignored");
  endtask

  task automatic t_range();
    m1_cycle(16'h0000, HOST, "R1 map for range test");
    rd_check(16'h8000, NONE, "R8 outside low 16K");
    rd_check(16'h4000, NONE, "R8 just above 16K");
    ph_rfsh(); chk_sel("R8 none during refresh", NONE); idle();
    chk_sel("R8 none when idle", NONE);
    unmap_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_data_no_trap();
    t_entry_delay();
    t_each_entry();
    t_imm();
    t_boundaries();
    t_nested_nmi();
    t_bank();
    t_force();
    t_port_mismatch();
    t_range();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule